// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block gives a processor access to the internal control registers of a serial PHY through a small window of six host-side registers. Software loads the write data, sets the lane enable and takes the PHY out of reset. It then writes a command word that holds the PHY register address, a direction flag and a rate-group flag. The bridge turns that command into one request/acknowledge transaction on a simple PHY-side register port. When the transaction ends, the bridge raises a completion bit that software can poll.

Software closes each access by writing a command word with no direction flag set. That idle write clears the completion flag and makes the bridge ready for the next access. A read returns its PHY data in a read-data register, and the data is present by the time completion is visible. If the PHY never answers, a timeout counter ends the request and marks the access as failed, so a polling loop always finishes.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset, every window register reads zero, no PHY request is pending, and the lane-enable, PHY-reset and soft-reset outputs are low.
- R2: Window offsets: 0 command (bits 10:0 kept, higher bits read 0), 1 write data (all bits), 2 access enable (bit 0), 3 reset control (bits 1:0), 4 read data, 5 status. Host writes to offsets 4 and 5 have no effect, and offsets 6 and 7 read zero.
- R3: In the command word, bit 8 requests a PHY write, bits 7:0 give the PHY register address and bit 10 selects the alternate rate group. When such a command is accepted, `phy_req_o` is high one cycle after the write, with `phy_we_o`=1, the address, the group flag and the write-data register on the PHY port.
- R4: Bit 9 of the command word requests a PHY read (`phy_we_o`=0). The PHY read data is stored into offset 4 on the clock edge that samples `phy_ack_i`, so it is valid when completion reads 1. Write accesses leave offset 4 unchanged.
- R5: `phy_req_o` stays high until `phy_ack_i` is sampled. In the following cycle the request is low and status bit 0 (done) reads 1.
- R6: A command write with bits 9:8 both zero clears both status bits and returns the bridge to idle. A command written while status bit 0 is still 1 starts nothing.
- R7: No access starts if bits 9:8 of the command are both 1 or both 0, if access-enable bit 0 is clear, or if reset-control bit 1 (PHY reset) is set.
- R8: If no acknowledge arrives during TIMEOUT_CYCLES cycles of request, the request drops and status reads 3 (bit 0 done, bit 1 timeout error).
- R9: An acknowledge sampled in the last cycle of the timeout window counts as success: status reads 1 and the error bit stays clear.
- R10: `phy_rst_o` follows reset-control bit 1, `phy_srst_o` follows bit 0, and `lane_en_o` follows access-enable bit 0.
- R11: While an access is in progress, host writes to offsets 0 and 1 are ignored, so the PHY port stays stable. An acknowledge with no request pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register word offset |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data for host_addr (combinational) |
| phy_req_o | output | 1 | PHY-side access request |
| phy_we_o | output | 1 | PHY access direction, 1 = write |
| phy_addr_o | output | PHY_AW | PHY register address |
| phy_grp_o | output | 1 | Alternate rate-group select |
| phy_wdata_o | output | DW | Data for PHY writes |
| phy_rdata_i | input | DW | Data returned by PHY reads |
| phy_ack_i | input | 1 | PHY access acknowledge |
| lane_en_o | output | 1 | Lane select / access enable |
| phy_rst_o | output | 1 | PHY reset |
| phy_srst_o | output | 1 | PHY soft reset |

## Verification
Two events can land on the same clock edge: the PHY acknowledge and the expiry of the timeout counter. The bench provokes this with a PHY model whose latency equals TIMEOUT_CYCLES, so the acknowledge is sampled in the final cycle of the window. It then checks that the status reads done without the error bit. A latency one cycle longer must give done with the error bit set, and the request must drop at exactly the same edge in both cases.

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge #(
  parameter int DW             = 32,
  parameter int PHY_AW         = 8,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              phy_req_o,
  output logic              phy_we_o,
  output logic [PHY_AW-1:0] phy_addr_o,
  output logic              phy_grp_o,
  output logic [DW-1:0]     phy_wdata_o,
  input  logic [DW-1:0]     phy_rdata_i,
  input  logic              phy_ack_i,
  output logic              lane_en_o,
  output logic              phy_rst_o,
  output logic              phy_srst_o
);

  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic [10:0]   cmd_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          lane_q;
  logic [1:0]    rctl_q;
  logic          busy_q, done_q, err_q;
  logic [CW-1:0] cnt_q;

  logic wr_cmd, wr_dat, cmd_ok, go, idle_wr;

  assign wr_cmd  = host_we && host_addr == 3'd0 && !busy_q;
  assign wr_dat  = host_we && host_addr == 3'd1 && !busy_q;
  assign cmd_ok  = host_wdata[8] ^ host_wdata[9];
  assign go      = wr_cmd && cmd_ok && !done_q && lane_q && !rctl_q[1];
  assign idle_wr = wr_cmd && host_wdata[9:8] == 2'b00;

  assign phy_req_o   = busy_q;
  assign phy_we_o    = cmd_q[8];
  assign phy_grp_o   = cmd_q[10];
  assign phy_addr_o  = cmd_q[PHY_AW-1:0];
  assign phy_wdata_o = wdata_q;
  assign lane_en_o   = lane_q;
  assign phy_rst_o   = rctl_q[1];
  assign phy_srst_o  = rctl_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      wdata_q <= '0;
      lane_q  <= 1'b0;
      rctl_q  <= '0;
    end else begin
      if (wr_cmd) cmd_q <= host_wdata[10:0];
      if (wr_dat) wdata_q <= host_wdata;
      if (host_we && host_addr == 3'd2) lane_q <= host_wdata[0];
      if (host_we && host_addr == 3'd3) rctl_q <= host_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (go) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (phy_ack_i) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (cmd_q[9]) rdata_q <= phy_rdata_i;
        end else if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (idle_wr) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    case (host_addr)
      3'd0:    host_rdata = DW'(cmd_q);
      3'd1:    host_rdata = wdata_q;
      3'd2:    host_rdata = DW'(lane_q);
      3'd3:    host_rdata = DW'(rctl_q);
      3'd4:    host_rdata = rdata_q;
      3'd5:    host_rdata = DW'({err_q, done_q});
      default: host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/phy_reg_bridge_chk.sv
module phy_reg_bridge_chk #(
  parameter int DW     = 32,
  parameter int PHY_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phy_req,
  input logic              phy_ack,
  input logic              phy_we,
  input logic [PHY_AW-1:0] phy_addr,
  input logic              phy_grp,
  input logic [DW-1:0]     phy_wdata,
  input logic              lane_en,
  input logic              phy_rst,
  input logic              done,
  input logic              err
);

  // R7: a request only begins with the lane enabled and the PHY out of reset
  assert_start_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_req) |-> ($past(lane_en) && !$past(phy_rst)));

  // R5: the request is held until acknowledged or timed out
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && !phy_ack) |=> (phy_req || err));

  // R5: an acknowledge ends the request and reports success
  assert_ack_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && phy_ack) |=> (!phy_req && done && !err));

  // R6: completion and a pending request never coexist
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(phy_req && done));

  // R11: PHY port fields stay stable while a request is pending
  assert_port_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && $past(phy_req)) |->
      ($stable(phy_addr) && $stable(phy_wdata) && $stable(phy_we) && $stable(phy_grp)));

  // R8: the error flag only appears together with completion
  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

endmodule

bind phy_reg_bridge phy_reg_bridge_chk #(.DW(DW), .PHY_AW(PHY_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phy_req(phy_req_o), .phy_ack(phy_ack_i),
  .phy_we(phy_we_o), .phy_addr(phy_addr_o), .phy_grp(phy_grp_o),
  .phy_wdata(phy_wdata_o), .lane_en(lane_en_o), .phy_rst(phy_rst_o),
  .done(done_q), .err(err_q)
);

// File: tb/tb_phy_reg_bridge.sv
module tb_phy_reg_bridge;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int T  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0, host_rdata;
  logic phy_req, phy_we, phy_grp, phy_ack;
  logic [AW-1:0] phy_addr;
  logic [DW-1:0] phy_wdata, phy_rdata = '0;
  logic lane_en, phy_rst, phy_srst;

  logic resp_ack = 1'b0, force_ack = 1'b0;
  int lat = 1, rcnt = 0;
  logic [DW-1:0] resp_data = '0;
  int n_chk = 0, n_fail = 0;

  assign phy_ack = resp_ack | force_ack;

  always #2 clk = ~clk;

  phy_reg_bridge #(.DW(DW), .PHY_AW(AW), .TIMEOUT_CYCLES(T)) dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .phy_req_o(phy_req),
    .phy_we_o(phy_we), .phy_addr_o(phy_addr), .phy_grp_o(phy_grp),
    .phy_wdata_o(phy_wdata), .phy_rdata_i(phy_rdata), .phy_ack_i(phy_ack),
    .lane_en_o(lane_en), .phy_rst_o(phy_rst), .phy_srst_o(phy_srst));

  always @(negedge clk) begin
    if (resp_ack) begin
      resp_ack = 1'b0;
      rcnt = 0;
    end else if (phy_req) begin
      rcnt = rcnt + 1;
      if (rcnt >= lat) begin
        resp_ack = 1'b1;
        phy_rdata = resp_data;
      end
    end else begin
      rcnt = 0;
    end
  end

  // {en, rst, cmd[10:0], wdata, phy rdata, expect start}
  localparam logic [77:0] VEC [8] = '{
    {1'b1, 1'b0, 11'h143, 32'h0020_0188, 32'hDEAD_0001, 1'b1},
    {1'b1, 1'b0, 11'h543, 32'h2000_0000, 32'hDEAD_0002, 1'b1},
    {1'b1, 1'b0, 11'h25A, 32'h0000_0000, 32'hA5A5_0F0F, 1'b1},
    {1'b1, 1'b0, 11'h660, 32'h1111_2222, 32'h28E8_0000, 1'b1},
    {1'b1, 1'b0, 11'h352, 32'h3333_4444, 32'hDEAD_0005, 1'b0},
    {1'b1, 1'b0, 11'h052, 32'h5555_6666, 32'hDEAD_0006, 1'b0},
    {1'b0, 1'b0, 11'h110, 32'h7777_8888, 32'hDEAD_0007, 1'b0},
    {1'b1, 1'b1, 11'h210, 32'h9999_AAAA, 32'hDEAD_0008, 1'b0}
  };

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [DW-1:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic wait_done();
    logic [DW-1:0] s;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      peek(3'd5, s);
      if (s[0]) break;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d, exp_rd;
    exp_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      peek(3'(a), d);
      check("R1 reg after reset", d, '0);
    end
    check("R1 req/outs", {28'd0, phy_req, lane_en, phy_rst, phy_srst}, '0);

    // R2 register map, R10 outputs
    wr(3'd0, 32'hFFFF_FFFF); peek(3'd0, d); check("R2 cmd readback", d, 32'h7FF);
    check("R7 both bits no start", {31'd0, phy_req}, 0);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'hCAFE_BABE); peek(3'd1, d); check("R2 wdata readback", d, 32'hCAFE_BABE);
    wr(3'd2, 32'hFFFF_FFFF); peek(3'd2, d); check("R2 enable readback", d, 32'h1);
    wr(3'd3, 32'hFFFF_FFFF); peek(3'd3, d); check("R2 reset readback", d, 32'h3);
    check("R10 outputs set", {29'd0, lane_en, phy_rst, phy_srst}, 32'h7);
    wr(3'd3, 32'h0);
    check("R10 outputs reset cleared", {30'd0, phy_rst, phy_srst}, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF); peek(3'd4, d); check("R2 rdata not writable", d, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF); peek(3'd5, d); check("R2 status not writable", d, 32'h0);
    peek(3'd6, d); check("R2 offset 6", d, 32'h0);
    peek(3'd7, d); check("R2 offset 7", d, 32'h0);

    // table of accesses: R3 R4 R6 R7
    lat = 1;
    for (int i = 0; i < 8; i++) begin
      logic [77:0] v;
      v = VEC[i];
      wr(3'd2, {31'd0, v[77]});
      wr(3'd3, {30'd0, v[76], 1'b0});
      wr(3'd1, v[64:33]);
      resp_data = v[32:1];
      wr(3'd0, {21'd0, v[75:65]});
      check($sformatf("R3/R7 vec%0d start", i), {31'd0, phy_req}, {31'd0, v[0]});
      if (v[0]) begin
        check($sformatf("R3 vec%0d we", i), {31'd0, phy_we}, {31'd0, v[73]});
        check($sformatf("R3 vec%0d addr", i), {24'd0, phy_addr}, {24'd0, v[72:65]});
        check($sformatf("R3 vec%0d grp", i), {31'd0, phy_grp}, {31'd0, v[75]});
        check($sformatf("R3 vec%0d wdata", i), phy_wdata, v[64:33]);
        wait_done();
        peek(3'd5, d); check($sformatf("R5 vec%0d status", i), d, 32'h1);
        if (v[74]) exp_rd = v[32:1];
        peek(3'd4, d); check($sformatf("R4 vec%0d rdata", i), d, exp_rd);
        wr(3'd0, 32'h0);
        peek(3'd5, d); check($sformatf("R6 vec%0d idle clears", i), d, 32'h0);
      end else begin
        repeat (3) @(negedge clk);
        check($sformatf("R7 vec%0d no req", i), {31'd0, phy_req}, 0);
        peek(3'd5, d); check($sformatf("R7 vec%0d status", i), d, 32'h0);
        wr(3'd3, 32'h0);
        wr(3'd0, 32'h0);
      end
    end
    wr(3'd2, 32'h1);

    // R5 request held for latency 3
    lat = 3;
    wr(3'd0, 32'h120);
    check("R5 req raised", {31'd0, phy_req}, 1);
    @(negedge clk); check("R5 held c1", {31'd0, phy_req}, 1);
    @(negedge clk); check("R5 held c2", {31'd0, phy_req}, 1);
    peek(3'd5, d); check("R5 not done yet", d, 32'h0);
    @(negedge clk); check("R5 req dropped", {31'd0, phy_req}, 0);
    peek(3'd5, d); check("R5 done after ack", d, 32'h1);

    // R6 command while done starts nothing
    wr(3'd0, 32'h121);
    check("R6 no start while done", {31'd0, phy_req}, 0);
    peek(3'd5, d); check("R6 status kept", d, 32'h1);
    wr(3'd0, 32'h0);
    peek(3'd0, d); check("R6 idle readback", d, 32'h0);

    // R11 writes during busy ignored
    lat = 6;
    wr(3'd1, 32'h0BAD_F00D);
    wr(3'd0, 32'h133);
    wr(3'd0, 32'h1FF);
    wr(3'd1, 32'h1234_5678);
    peek(3'd0, d); check("R11 cmd frozen", d, 32'h133);
    peek(3'd1, d); check("R11 wdata frozen", d, 32'h0BAD_F00D);
    check("R11 phy addr", {24'd0, phy_addr}, 32'h33);
    wait_done();
    wr(3'd0, 32'h0);
    // R11 spurious acknowledge
    @(negedge clk); force_ack = 1'b1;
    @(negedge clk); force_ack = 1'b0;
    @(negedge clk);
    peek(3'd5, d); check("R11 stray ack ignored", d, 32'h0);

    // R9 ack in last cycle of window
    lat = T;
    wr(3'd0, 32'h244);
    repeat (T - 1) @(negedge clk);
    check("R9 still requesting", {31'd0, phy_req}, 1);
    @(negedge clk);
    check("R9 req dropped", {31'd0, phy_req}, 0);
    peek(3'd5, d); check("R9 success no error", d, 32'h1);
    wr(3'd0, 32'h0);

    // R8 timeout
    lat = T + 1;
    wr(3'd0, 32'h245);
    repeat (T - 1) @(negedge clk);
    check("R8 still requesting", {31'd0, phy_req}, 1);
    @(negedge clk);
    check("R8 req dropped", {31'd0, phy_req}, 0);
    peek(3'd5, d); check("R8 timeout status", d, 32'h3);
    wr(3'd0, 32'h0);
    peek(3'd5, d); check("R8/R6 idle clears error", d, 32'h0);

    finish_run();
  end
endmodule